// File: doc/BRIEF.md
# Single-Channel to Balanced I2S Splitter

This block sits between an audio receiver that emits stereo I2S and a pair of DACs wired as a differential output. It takes one channel of the incoming stream and builds a new I2S stream from it. The left output slot carries that sample as received. The right output slot carries its two's-complement negation, so the two DACs swing in opposite directions. A compile-time parameter picks which input channel is the source.

The whole design runs on the rising edge of the incoming bit clock. A 64-bit shift register takes in every bit of every frame, including padding bits that are never used, so no bit-position counter is needed. When word select falls, a frame has just completed. The source sample is then taken from a fixed position in the register, negated with saturation, and loaded in parallel into an output shift register.

The output bit clock is the inverse of the input bit clock. The output word select is the input word select delayed by half a bit period. Output data changes only on the input rising edge, so it is steady whenever the output bit clock rises. After reset the output data stays at zero until one full frame has been captured.

Top module: `i2s_bal_top`

## Requirements
- R1: `bck_out` is always the logical inverse of `bck_in`.
- R2: `ws_out` takes the value of `ws_in` sampled at each rising edge of `bck_in`, which delays it by half a bit period.
- R3: Each output slot is 32 bits, sent MSB first. The MSB appears one bit period after the `ws_out` transition that opens the slot (`ws_out`=0 marks the left slot, 1 marks the right slot). The top `SAMPLE_W` bits carry the sample and the remaining low bits are zero. In the left slot, the sample equals the top `SAMPLE_W` bits of the source input slot.
- R4: The right output slot carries the two's-complement negation of the left-slot sample, taken over `SAMPLE_W` bits.
- R5: A source sample equal to the most negative code (only the sign bit set) gives the most positive code (all bits but the sign set) in the right slot.
- R6: `SRC` = `SRC_LEFT` takes the sample from the input slot with `ws_in`=0; `SRC_RIGHT` takes it from the slot with `ws_in`=1. The other input slot and the low unused bits of the source slot have no effect on the output.
- R7: The sample captured in input frame k is sent in the output frame that begins one frame later, with no frame skipped or repeated.
- R8: After reset `sd_out` and `ws_out` are 0. `sd_out` stays 0 until a full frame has been captured, which takes two falls of `ws_in` after reset.
- R9: `sd_out` changes only at rising edges of `bck_in`, so it is stable from a rising edge of `bck_out` back to the preceding falling edge of `bck_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bck_in | input | 1 | Incoming I2S bit clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_in | input | 1 | Incoming word select (0 = left slot) |
| sd_in | input | 1 | Incoming serial data, MSB first |
| bck_out | output | 1 | Outgoing bit clock, inverse of `bck_in` |
| ws_out | output | 1 | Outgoing word select, half a bit period behind `ws_in` |
| sd_out | output | 1 | Outgoing serial data: sample in the left slot, its negation in the right |

## Verification
Two instances run side by side on the same input stream: one takes the left channel at 24 bits, the other the right channel at 16 bits. Because the unselected channel always holds unrelated random data, any leak from the wrong channel shows up. Directed frames supply the most negative and most positive codes, zero, minus one, and values whose nonzero bits sit only below the sample width. These separate saturation from wrap-around, and show whether padding bits are truncated or leak through. The random frames that follow test the ordering and latency of the frame pipeline, and the first two decoded frames test the quiet period after reset.

// File: rtl/i2s_bal_pkg.sv
package i2s_bal_pkg;

    // Which incoming channel feeds the balanced pair
    typedef enum logic {
        SRC_LEFT  = 1'b0,
        SRC_RIGHT = 1'b1
    } src_sel_e;

endpackage

// File: rtl/i2s_bal_capture.sv
// Counterless frame capture: every incoming bit enters a frame-wide shift
// register; a falling word select closes the frame.
module i2s_bal_capture #(
    parameter int SLOT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ws_i,
    input  logic                  sd_i,
    output logic [2*SLOT_W-1:0]   frame_o,
    output logic                  frame_stb_o,
    output logic                  ws_dly_o
);

    localparam int FRAME_W = 2 * SLOT_W;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               ws_prev;
        logic               armed;
    } cap_state_t;

    cap_state_t st_q, st_d;
    logic       ws_fall;

    always_comb begin
        ws_fall       = st_q.ws_prev & ~ws_i;
        st_d.sr       = {st_q.sr[FRAME_W-2:0], sd_i};
        st_d.ws_prev  = ws_i;
        // first fall only marks the start of a frame that can be trusted
        st_d.armed    = st_q.armed | ws_fall;
    end

    // The frame including the bit arriving on this edge
    assign frame_o     = st_d.sr;
    assign frame_stb_o = ws_fall & st_q.armed;
    assign ws_dly_o    = st_q.ws_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2s_bal_negate.sv
// Two's-complement negation with the most negative code clamped.
module i2s_bal_negate #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] val_i,
    output logic [WIDTH-1:0] neg_o
);

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MOST_POS = {1'b0, {(WIDTH-1){1'b1}}};

    always_comb begin
        if (val_i == MOST_NEG) begin
            neg_o = MOST_POS;
        end else begin
            neg_o = ~val_i + {{(WIDTH-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/i2s_bal_serializer.sv
// Output shift register: parallel load at frame start, MSB-first shift,
// data registered so it moves only on the input rising edge.
module i2s_bal_serializer #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sd_o
);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               sd;
    } ser_state_t;

    ser_state_t st_q, st_d;

    always_comb begin
        st_d.sd = st_q.sr[FRAME_W-1];
        if (load_i) begin
            st_d.sr = frame_i;
        end else begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], 1'b0};
        end
    end

    assign sd_o = st_q.sd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/i2s_bal_top.sv
module i2s_bal_top #(
    parameter int                   SLOT_W   = 32,
    parameter int                   SAMPLE_W = 24,
    parameter i2s_bal_pkg::src_sel_e SRC     = i2s_bal_pkg::SRC_LEFT
) (
    input  logic bck_in,
    input  logic rst_n,
    input  logic ws_in,
    input  logic sd_in,
    output logic bck_out,
    output logic ws_out,
    output logic sd_out
);

    localparam int FRAME_W = 2 * SLOT_W;
    // MSB index of the selected input slot inside the captured frame
    localparam int SRC_MSB = (SRC == i2s_bal_pkg::SRC_RIGHT) ? SLOT_W - 1 : FRAME_W - 1;

    logic [FRAME_W-1:0]  in_frame;
    logic                frame_stb;
    logic [SAMPLE_W-1:0] sample;
    logic [SAMPLE_W-1:0] sample_neg;
    logic [SLOT_W-1:0]   pos_slot;
    logic [SLOT_W-1:0]   neg_slot;
    logic [FRAME_W-1:0]  out_frame;

    i2s_bal_capture #(
        .SLOT_W (SLOT_W)
    ) u_capture (
        .clk         (bck_in),
        .rst_n       (rst_n),
        .ws_i        (ws_in),
        .sd_i        (sd_in),
        .frame_o     (in_frame),
        .frame_stb_o (frame_stb),
        .ws_dly_o    (ws_out)
    );

    assign sample = in_frame[SRC_MSB -: SAMPLE_W];

    i2s_bal_negate #(
        .WIDTH (SAMPLE_W)
    ) u_negate (
        .val_i (sample),
        .neg_o (sample_neg)
    );

    // Left-justify both samples in their slots, zero below
    always_comb begin
        pos_slot = '0;
        neg_slot = '0;
        pos_slot[SLOT_W-1 -: SAMPLE_W] = sample;
        neg_slot[SLOT_W-1 -: SAMPLE_W] = sample_neg;
        out_frame = {pos_slot, neg_slot};
    end

    i2s_bal_serializer #(
        .FRAME_W (FRAME_W)
    ) u_serializer (
        .clk     (bck_in),
        .rst_n   (rst_n),
        .load_i  (frame_stb),
        .frame_i (out_frame),
        .sd_o    (sd_out)
    );

    assign bck_out = ~bck_in;

endmodule

// File: rtl/i2s_bal_checker.sv
module i2s_bal_checker #(
    parameter int SLOT_W   = 32,
    parameter int SAMPLE_W = 24
) (
    input logic bck_in,
    input logic rst_n,
    input logic ws_in,
    input logic bck_out,
    input logic ws_out,
    input logic sd_out
);

    logic       past_ok;
    logic       ws_seen;
    logic [1:0] falls;
    logic [7:0] pos;
    logic       in_pad;

    always_ff @(posedge bck_in or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            ws_seen <= 1'b0;
            falls   <= '0;
            pos     <= 8'hFF;
        end else begin
            past_ok <= 1'b1;
            ws_seen <= ws_in;
            if (ws_seen && !ws_in) begin
                pos <= '0;
                if (falls != 2'd2) begin
                    falls <= falls + 2'd1;
                end
            end else if (pos != 8'hFF) begin
                pos <= pos + 8'd1;
            end
        end
    end

    // pos = k means sd_out now shows output frame bit 64-k
    always_comb begin
        in_pad = ((int'(pos) >= SAMPLE_W + 1) && (int'(pos) <= SLOT_W)) ||
                 ((int'(pos) >= SLOT_W + SAMPLE_W + 1) && (int'(pos) <= 2 * SLOT_W));
    end

    // R1: output clock inverted
    p_clk_inverted_r1: assert property (@(posedge bck_in) disable iff (!rst_n)
        bck_out != bck_in);

    // R2: word select delayed by one input rising edge
    p_ws_delay_r2: assert property (@(posedge bck_in) disable iff (!rst_n)
        past_ok |-> ws_out == $past(ws_in));

    // R8: quiet output until a full frame was captured
    p_quiet_start_r8: assert property (@(posedge bck_in) disable iff (!rst_n)
        (falls != 2'd2) |-> !sd_out);

    // R3: padding bits below the sample are zero
    p_zero_pad_r3: assert property (@(posedge bck_in) disable iff (!rst_n)
        (falls != 2'd0 && in_pad) |-> !sd_out);

endmodule

bind i2s_bal_top i2s_bal_checker #(
    .SLOT_W   (SLOT_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .bck_in  (bck_in),
    .rst_n   (rst_n),
    .ws_in   (ws_in),
    .bck_out (bck_out),
    .ws_out  (ws_out),
    .sd_out  (sd_out)
);

// File: tb/tb_i2s_bal_top.sv
module tb_i2s_bal_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NF         = 40;
    localparam int NT         = NF + 3;

    logic       bck_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic       ws_in  = 1'b1;
    logic       sd_in  = 1'b0;
    logic       run    = 1'b0;
    logic       done   = 1'b0;
    logic [1:0] bck_out, ws_out, sd_out;

    int nchk = 0;
    int nfail = 0;
    int dec [2] = '{0, 0};
    logic [63:0] mon_sh [2] = '{64'd0, 64'd0};
    logic        mon_wsp [2] = '{1'b0, 1'b0};
    logic [31:0] fl [NT];
    logic [31:0] fr [NT];

    always #(HALF) bck_in = ~bck_in;

    i2s_bal_top #(.SLOT_W(32), .SAMPLE_W(24), .SRC(i2s_bal_pkg::SRC_LEFT)) dut (
        .bck_in (bck_in), .rst_n (rst_n), .ws_in (ws_in), .sd_in (sd_in),
        .bck_out (bck_out[0]), .ws_out (ws_out[0]), .sd_out (sd_out[0]));

    i2s_bal_top #(.SLOT_W(32), .SAMPLE_W(16), .SRC(i2s_bal_pkg::SRC_RIGHT)) dut_alt (
        .bck_in (bck_in), .rst_n (rst_n), .ws_in (ws_in), .sd_in (sd_in),
        .bck_out (bck_out[1]), .ws_out (ws_out[1]), .sd_out (sd_out[1]));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int sw_of(int i);
        return (i == 0) ? 24 : 16;
    endfunction

    function automatic logic [31:0] mask_of(int i);
        return ~((32'h1 << (32 - sw_of(i))) - 32'h1);
    endfunction

    // R6: instance 0 uses the ws=0 slot, instance 1 the ws=1 slot
    function automatic logic [31:0] exp_pos(int i, logic [31:0] l, logic [31:0] r);
        return ((i == 0) ? l : r) & mask_of(i);
    endfunction

    function automatic logic [31:0] exp_neg(int i, logic [31:0] l, logic [31:0] r);
        logic [31:0] p = exp_pos(i, l, r);
        if (p == 32'h8000_0000) return 32'h7FFF_FFFF & mask_of(i);
        return -p;
    endfunction

    task automatic decode(int i, logic [63:0] sh);
        logic [31:0] gl = sh[63:32];
        logic [31:0] gr = sh[31:0];
        string pre = (i == 1) ? "R6 " : "";
        if (dec[i] < 2) begin
            chk({pre, "R8 quiet left slot"}, gl, 32'd0);
            chk({pre, "R8 quiet right slot"}, gr, 32'd0);
        end else if (dec[i] - 2 < NT) begin
            int k = dec[i] - 2;
            logic [31:0] ep = exp_pos(i, fl[k], fr[k]);
            chk({pre, "R3 R7 left slot"}, gl, ep);
            if (ep == 32'h8000_0000)
                chk({pre, "R5 saturated right slot"}, gr, exp_neg(i, fl[k], fr[k]));
            else
                chk({pre, "R4 negated right slot"}, gr, exp_neg(i, fl[k], fr[k]));
        end
        dec[i]++;
    endtask

    // Receiver: samples outputs on the output clock rising edge
    always @(negedge bck_in) begin
        if (run) begin
            for (int i = 0; i < 2; i++) begin
                logic [63:0] sh;
                sh = {mon_sh[i][62:0], sd_out[i]};
                chk("R2 ws_out follows sampled ws_in", {31'd0, ws_out[i]}, {31'd0, ws_in});
                if (mon_wsp[i] && !ws_out[i]) decode(i, sh);
                mon_sh[i]  = sh;
                mon_wsp[i] = ws_out[i];
            end
        end
    end

    // R1 and R9: clock inversion and data stability across the low phase
    always @(posedge bck_in) begin
        logic [1:0] held;
        if (run) begin
            #1;
            held = sd_out;
            chk("R1 bck_out high phase", {30'd0, bck_out}, {30'd0, ~{2{bck_in}}});
            @(negedge bck_in);
            #1;
            chk("R9 sd_out stable", {30'd0, sd_out}, {30'd0, held});
            chk("R1 bck_out low phase", {30'd0, bck_out}, {30'd0, ~{2{bck_in}}});
        end
    end

    initial begin
        logic [31:0] prev_r;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240607);
        for (int f = 0; f < NT; f++) begin
            fl[f] = $urandom;
            fr[f] = $urandom;
        end
        fl[0] = 32'h8000_0000; fr[0] = 32'h8000_0000;   // most negative
        fl[1] = 32'h7FFF_FFFF; fr[1] = 32'h7FFF_FFFF;   // most positive
        fl[2] = 32'h0000_0000; fr[2] = 32'h0000_0000;   // zero
        fl[3] = 32'hFFFF_FFFF; fr[3] = 32'hFFFF_FFFF;   // minus one, dirty pad
        fl[4] = 32'h0000_0100; fr[4] = 32'h0001_0000;   // LSB of each width
        fl[5] = 32'h8000_00FF; fr[5] = 32'h8000_FFFF;   // min with dirty pad
        fl[6] = 32'h0000_00FF; fr[6] = 32'h0000_FFFF;   // only unused bits set
        fl[7] = 32'h8000_0000; fr[7] = 32'h0000_5000;
        for (int f = NF; f < NT; f++) begin
            fl[f] = 32'd0;
            fr[f] = 32'd0;
        end

        repeat (3) @(negedge bck_in);
        #1;
        chk("R8 sd_out in reset", {30'd0, sd_out}, 32'd0);
        chk("R8 ws_out in reset", {30'd0, ws_out}, 32'd0);
        rst_n = 1'b1;
        run   = 1'b1;
        repeat (10) @(negedge bck_in);

        prev_r = 32'd0;
        for (int f = 0; f < NT; f++) begin
            for (int j = 0; j < 64; j++) begin
                @(negedge bck_in);
                #1;
                ws_in = (j >= 32);
                if (j == 0)       sd_in = prev_r[0];
                else if (j <= 32) sd_in = fl[f][32 - j];
                else              sd_in = fr[f][64 - j];
            end
            prev_r = fr[f];
        end
        repeat (8) @(negedge bck_in);

        chk("R7 frames decoded main", dec[0], NT);
        chk("R6 R7 frames decoded alt", dec[1], NT);
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule